// File: doc/BRIEF.md
# Debug Break Saved-PC Selector

This block sits beside the retire stage of a simple in-order core and turns break-comparator hits into a debug trap. It decides two things: whether the current instruction is allowed to execute, and which program counter is saved for the handler. The core gives it one instruction slot per cycle: the slot's address, the address that follows it in execution order, flags for a delayed branch and for its delay slot, and the branch target. It also gives four match pulses, one per condition type.

A break taken before execution blocks the matched instruction at once. A break taken after execution, and a data-address break, let the instruction finish and trap at the next boundary. A data-value break traps one instruction later. No trap may split a delayed branch from its delay slot. After a trap is raised, the block ignores everything until the core acknowledges the trap.

Top module: `dbg_brk_pc_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `trap_req` and `suppress` are 0 after that edge and `saved_pc` is 0.
- R2: When the block is idle and `in_valid` and `match_pre` are both high, `suppress` is high in that same cycle. `trap_req` pulses in the next cycle, with `saved_pc` equal to `in_pc` when `in_dslot` is 0.
- R3: A pre-execution match on a slot with `in_dslot`=1 saves the address of the most recent delayed branch that executed (`in_dbranch`=1).
- R4: A post-execution match (`match_post`) on an instruction that is not a delayed branch does not suppress it. `trap_req` pulses in the next cycle with `saved_pc` = `in_next_pc` of that instruction.
- R5: A post-execution or data-address match on a delayed branch raises no trap for the branch itself. Once the next valid instruction (the delay slot) executes, `trap_req` pulses in the following cycle with `saved_pc` = the branch's `in_target`.
- R6: A data-address match (`match_dadr`) behaves like a post-execution match: the instruction executes and `saved_pc` is its `in_next_pc`.
- R7: A data-value match (`match_dval`) lets DATA_LAT (default 1) more valid instructions execute. The trap is then taken at the boundary after the last of them, and `saved_pc` is that instruction's `in_next_pc`. If that instruction is a delayed branch, the boundary moves past its delay slot and `saved_pc` is the target.
- R8: A pre-execution match wins over any other match on the same instruction, and over any deferred trap still waiting. The saved PC follows R2 or R3, and the deferred trap is dropped.
- R9: `trap_req` is high for exactly one cycle per trap. `saved_pc` changes only in a cycle where `trap_req` is high.
- R10: From the trap pulse until a cycle with `trap_ack` high, matches are ignored: no suppress and no new trap. The block is live again in the cycle after the acknowledge.
- R11: Cycles with `in_valid` low neither execute, count towards the DATA_LAT window, nor complete a pending delay-slot wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_pc | input | AW | Address of the presented instruction |
| in_next_pc | input | AW | Address of the instruction that follows in execution order |
| in_dbranch | input | 1 | Presented instruction is a delayed branch |
| in_dslot | input | 1 | Presented instruction sits in a delay slot |
| in_target | input | AW | Branch target of a delayed branch |
| match_pre | input | 1 | Fetch match, break before execution |
| match_post | input | 1 | Fetch match, break after execution |
| match_dadr | input | 1 | Data access match on address only |
| match_dval | input | 1 | Data access match on address and data |
| trap_ack | input | 1 | Core has taken the trap; re-arm |
| trap_req | output | 1 | One-cycle trap request |
| suppress | output | 1 | Do not execute the presented instruction |
| saved_pc | output | AW | PC to save for the handler |

## Verification
The bench aims at the places where the saved PC is easy to get wrong:
- A pre-execution hit in a delay slot. A design that saves the slot's own address would resume in the slot and skip the branch.
- A post-execution hit on a delayed branch. A design that traps too early returns to the slot address, or traps before the slot executes.
- A data-value hit whose latency window spans a bubble or a delayed branch. A design that counts the bubble traps one instruction early; one that ignores the branch splits the branch from its slot.
- A pre-execution hit arriving on top of a pending deferred trap. If the pending trap were not dropped, a second trap would fire after the acknowledge.

Matches presented while a trap waits for its acknowledge are also checked, so a design that re-triggers shows up as an extra pulse or a changed saved PC.

// File: rtl/dbg_brk_pkg.sv
// Package: shared types for the debug break saved-PC selector.
// Assumes: nothing beyond a single clock domain.
package dbg_brk_pkg;

    // Trap controller state: armed and waiting for matches, or holding a raised trap
    typedef enum logic {
        BRK_IDLE    = 1'b0,
        BRK_TRAPPED = 1'b1
    } brk_state_e;

endpackage

// File: rtl/brk_pre_path.sv
// Module: pre-execution break path.
// Decides in the current cycle whether the presented instruction must be
// blocked, and which address goes into the saved PC for such a break.
// Also derives the "instruction executes" strobe used by the deferred path.
// Assumes: a delay slot is always preceded by its delayed branch in the
// executed stream, so the last executed branch address is the right one.
module brk_pre_path #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          in_valid,
    input  logic [AW-1:0] in_pc,
    input  logic          in_dbranch,
    input  logic          in_dslot,
    input  logic          match_pre,
    output logic          pre_fire,
    output logic [AW-1:0] pre_pc,
    output logic          retire
);

    logic [AW-1:0] last_br_q;

    // Blocking decision and execute strobe for the presented instruction
    always_comb begin
        pre_fire = active && in_valid && match_pre;
        retire   = active && in_valid && !match_pre;
        pre_pc   = in_dslot ? last_br_q : in_pc;
    end

    // Remember the address of the latest delayed branch that executed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_br_q <= '0;
        end else if (retire && in_dbranch) begin
            last_br_q <= in_pc;
        end
    end

endmodule

// File: rtl/brk_defer_track.sv
// Module: deferred (post-execution) break tracker.
// Holds breaks that trap at a later instruction boundary: post-execution
// fetch and address-only data matches trap after the matching instruction,
// address-plus-data matches after DATA_LAT further executed instructions.
// A boundary that falls on a delayed branch is moved past its delay slot,
// and the branch target becomes the saved PC.
// Assumes: DATA_LAT >= 1; flush clears everything at once.
module brk_defer_track #(
    parameter int AW       = 32,
    parameter int DATA_LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire,
    input  logic          flush,
    input  logic          in_dbranch,
    input  logic [AW-1:0] in_next_pc,
    input  logic [AW-1:0] in_target,
    input  logic          match_post,
    input  logic          match_dadr,
    input  logic          match_dval,
    output logic          defer_fire,
    output logic [AW-1:0] defer_pc
);

    localparam int CW = (DATA_LAT > 1) ? $clog2(DATA_LAT) : 1;

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          wait_q;
    logic [AW-1:0] tgt_q;
    logic          due;
    logic          slot_done;

    // Is a trap boundary reached by the instruction executing now
    always_comb begin
        due        = retire && !wait_q &&
                     ((armed_q && cnt_q == '0) || match_post || match_dadr);
        slot_done  = retire && wait_q;
        defer_fire = slot_done || (due && !in_dbranch);
        defer_pc   = slot_done ? tgt_q : in_next_pc;
    end

    // Advance the latency window and the delay-slot wait on executed instructions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            wait_q  <= 1'b0;
            tgt_q   <= '0;
        end else if (flush || defer_fire) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            wait_q  <= 1'b0;
        end else if (retire) begin
            if (due) begin
                wait_q  <= 1'b1;
                tgt_q   <= in_target;
                armed_q <= 1'b0;
            end else if (armed_q) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (match_dval) begin
                armed_q <= 1'b1;
                cnt_q   <= CW'(DATA_LAT - 1);
            end
        end
    end

endmodule

// File: rtl/brk_trap_ctrl.sv
// Module: trap controller.
// Turns a break decision into a one-cycle trap pulse, latches the saved PC,
// and then ignores further breaks until the core acknowledges the trap.
// Assumes: pre-execution breaks are given priority over deferred ones.
module brk_trap_ctrl
    import dbg_brk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_fire,
    input  logic [AW-1:0] pre_pc,
    input  logic          defer_fire,
    input  logic [AW-1:0] defer_pc,
    input  logic          trap_ack,
    output logic          active,
    output logic          trap_req,
    output logic [AW-1:0] saved_pc
);

    brk_state_e state_q;

    // Expose whether breaks are being accepted
    always_comb begin
        active = (state_q == BRK_IDLE);
    end

    // Raise the trap, capture the saved PC, wait for acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BRK_IDLE;
            trap_req <= 1'b0;
            saved_pc <= '0;
        end else begin
            trap_req <= 1'b0;
            case (state_q)
                BRK_IDLE: begin
                    if (pre_fire) begin
                        trap_req <= 1'b1;
                        saved_pc <= pre_pc;
                        state_q  <= BRK_TRAPPED;
                    end else if (defer_fire) begin
                        trap_req <= 1'b1;
                        saved_pc <= defer_pc;
                        state_q  <= BRK_TRAPPED;
                    end
                end
                BRK_TRAPPED: begin
                    if (trap_ack) begin
                        state_q <= BRK_IDLE;
                    end
                end
                default: state_q <= BRK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dbg_brk_pc_sel.sv
// Module: debug break saved-PC selector, top level.
// Combines the pre-execution path, the deferred tracker and the trap
// controller. suppress is combinational on the presented instruction;
// trap_req and saved_pc are registered and appear one cycle after the
// deciding instruction.
// Assumes: one instruction slot per cycle, qualified by in_valid.
module dbg_brk_pc_sel #(
    parameter int AW       = 32,
    parameter int DATA_LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_pc,
    input  logic [AW-1:0] in_next_pc,
    input  logic          in_dbranch,
    input  logic          in_dslot,
    input  logic [AW-1:0] in_target,
    input  logic          match_pre,
    input  logic          match_post,
    input  logic          match_dadr,
    input  logic          match_dval,
    input  logic          trap_ack,
    output logic          trap_req,
    output logic          suppress,
    output logic [AW-1:0] saved_pc
);

    logic          active;
    logic          pre_fire;
    logic [AW-1:0] pre_pc;
    logic          retire;
    logic          defer_fire;
    logic [AW-1:0] defer_pc;

    brk_pre_path #(.AW(AW)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .in_valid   (in_valid),
        .in_pc      (in_pc),
        .in_dbranch (in_dbranch),
        .in_dslot   (in_dslot),
        .match_pre  (match_pre),
        .pre_fire   (pre_fire),
        .pre_pc     (pre_pc),
        .retire     (retire)
    );

    brk_defer_track #(.AW(AW), .DATA_LAT(DATA_LAT)) u_defer (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire     (retire),
        .flush      (pre_fire),
        .in_dbranch (in_dbranch),
        .in_next_pc (in_next_pc),
        .in_target  (in_target),
        .match_post (match_post),
        .match_dadr (match_dadr),
        .match_dval (match_dval),
        .defer_fire (defer_fire),
        .defer_pc   (defer_pc)
    );

    brk_trap_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_fire   (pre_fire),
        .pre_pc     (pre_pc),
        .defer_fire (defer_fire),
        .defer_pc   (defer_pc),
        .trap_ack   (trap_ack),
        .active     (active),
        .trap_req   (trap_req),
        .saved_pc   (saved_pc)
    );

    // Block the presented instruction on a pre-execution break
    always_comb begin
        suppress = pre_fire;
    end

endmodule

// File: rtl/dbg_brk_pc_sel_chk.sv
// Module: assertion checker for dbg_brk_pc_sel, attached by bind.
// Watches only the top-level ports.
module dbg_brk_pc_sel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          match_pre,
    input logic          trap_ack,
    input logic          suppress,
    input logic          trap_req,
    input logic [AW-1:0] saved_pc
);

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!trap_req && saved_pc == '0));

    // R2: a blocked instruction always carries a pre-execution match
    a_r2_supp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> (in_valid && match_pre));

    // R2: a blocked instruction is followed by a trap pulse
    a_r2_supp_traps: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |=> trap_req);

    // R9: the trap request lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    // R9: the saved PC moves only together with a trap pulse
    a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(saved_pc) |-> trap_req);

    // R10: nothing is blocked while a freshly raised trap is pending
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !suppress);

    // R10: without an acknowledge, no second trap follows in the next cycle
    a_r10_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> !suppress);

endmodule

bind dbg_brk_pc_sel dbg_brk_pc_sel_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .match_pre (match_pre),
    .trap_ack  (trap_ack),
    .suppress  (suppress),
    .trap_req  (trap_req),
    .saved_pc  (saved_pc)
);

// File: tb/dbg_brk_pc_sel_bench.sv
// Bench for dbg_brk_pc_sel: directed corner cases, then a seeded random
// instruction stream, checked against a behavioural model of the requirements.
module dbg_brk_pc_sel_bench;

    localparam int AW  = 32;
    localparam int LAT = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_pc = '0;
    logic [AW-1:0] in_next_pc = '0;
    logic          in_dbranch = 1'b0;
    logic          in_dslot = 1'b0;
    logic [AW-1:0] in_target = '0;
    logic          match_pre = 1'b0;
    logic          match_post = 1'b0;
    logic          match_dadr = 1'b0;
    logic          match_dval = 1'b0;
    logic          trap_ack = 1'b0;
    logic          trap_req;
    logic          suppress;
    logic [AW-1:0] saved_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit            m_trapped = 1'b0;
    bit            m_armed = 1'b0;
    int            m_cnt = 0;
    bit            m_wait = 1'b0;
    logic [AW-1:0] m_tgt = '0;
    logic [AW-1:0] m_lastbr = '0;
    bit            exp_trap = 1'b0;
    logic [AW-1:0] exp_saved = '0;
    string         exp_tag = "R9";

    always #4 clk = ~clk;  // 125 MHz

    dbg_brk_pc_sel #(.AW(AW), .DATA_LAT(LAT)) u_dbg_brk_pc_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_next_pc(in_next_pc), .in_dbranch(in_dbranch), .in_dslot(in_dslot),
        .in_target(in_target), .match_pre(match_pre), .match_post(match_post),
        .match_dadr(match_dadr), .match_dval(match_dval), .trap_ack(trap_ack),
        .trap_req(trap_req), .suppress(suppress), .saved_pc(saved_pc)
    );

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, check suppress, then check registered outputs
    task automatic cyc(bit v, logic [AW-1:0] pc, logic [AW-1:0] nxt, bit db, bit ds,
                       logic [AW-1:0] tgt, bit mp, bit mpo, bit mda, bit mdv, bit ack);
        bit pre, ret, fire, was_trapped, pending;
        logic [AW-1:0] fpc;
        string tag;
        in_valid = v; in_pc = pc; in_next_pc = nxt; in_dbranch = db; in_dslot = ds;
        in_target = tgt; match_pre = mp; match_post = mpo; match_dadr = mda;
        match_dval = mdv; trap_ack = ack;
        #1;
        was_trapped = m_trapped;
        pending = m_armed || m_wait;
        pre  = !m_trapped && v && mp;
        ret  = !m_trapped && v && !mp;
        fire = 1'b0; fpc = '0; tag = "R9";
        check(m_trapped ? "R10" : "R2", AW'(suppress), AW'(pre), "suppress");
        if (pre) begin
            fire = 1'b1;
            fpc  = ds ? m_lastbr : pc;
            tag  = (mpo || mda || mdv || pending) ? "R8" : (ds ? "R3" : "R2");
            m_armed = 1'b0; m_wait = 1'b0;
        end else if (ret) begin
            if (m_wait) begin
                fire = 1'b1; fpc = m_tgt; tag = "R5"; m_wait = 1'b0;
            end else if ((m_armed && m_cnt == 0) || mpo || mda) begin
                if (db) begin
                    m_wait = 1'b1; m_tgt = tgt; m_armed = 1'b0;
                end else begin
                    fire = 1'b1; fpc = nxt;
                    tag = m_armed ? "R7" : (mpo ? "R4" : "R6");
                    m_armed = 1'b0;
                end
            end else if (m_armed) begin
                m_cnt--;
            end else if (mdv) begin
                m_armed = 1'b1; m_cnt = LAT - 1;
            end
            if (db) m_lastbr = pc;
        end
        if (was_trapped) begin
            if (ack) m_trapped = 1'b0;
            exp_trap = 1'b0; exp_tag = "R10";
        end else begin
            exp_trap = fire; exp_tag = fire ? tag : "R11";
            if (fire) begin
                m_trapped = 1'b1; exp_saved = fpc;
            end
        end
        @(negedge clk);
        check(exp_tag, AW'(trap_req), AW'(exp_trap), "trap_req");
        check(exp_trap ? exp_tag : "R9", saved_pc, exp_saved, "saved_pc");
    endtask

    task automatic ins(logic [AW-1:0] pc, bit mp, bit mpo, bit mda, bit mdv);
        cyc(1'b1, pc, pc + 4, 1'b0, 1'b0, '0, mp, mpo, mda, mdv, 1'b0);
    endtask

    task automatic idle(bit ack);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, ack);
    endtask

    // Release the trap: R10 matches offered while trapped, then acknowledge
    task automatic release_trap();
        cyc(1'b1, 32'hF000, 32'hF004, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        idle(1'b1);
        idle(1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] rpc, rtgt, tgt;
        bit prev_br, v, db;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", AW'(trap_req), '0, "trap_req");
        check("R1", AW'(suppress), '0, "suppress");
        check("R1", saved_pc, '0, "saved_pc");
        rst_n = 1'b1;
        idle(1'b0);

        ins(32'h100, 1, 0, 0, 0);                    // R2
        release_trap();
        cyc(1, 32'h200, 32'h204, 1, 0, 32'h800, 0, 0, 0, 0, 0);
        cyc(1, 32'h204, 32'h800, 0, 1, '0, 1, 0, 0, 0, 0); // R3 -> 0x200
        release_trap();
        ins(32'h300, 0, 1, 0, 0);                    // R4 -> 0x304
        release_trap();
        cyc(1, 32'h400, 32'h404, 1, 0, 32'h900, 0, 1, 0, 0, 0);
        idle(0);                                     // R11 bubble in the slot wait
        cyc(1, 32'h404, 32'h900, 0, 1, '0, 0, 0, 0, 0, 0); // R5 -> 0x900
        release_trap();
        ins(32'h500, 0, 0, 1, 0);                    // R6 -> 0x504
        release_trap();
        ins(32'h600, 0, 0, 0, 1);
        idle(0);                                     // R11 bubble not counted
        ins(32'h604, 0, 0, 0, 0);                    // R7 -> 0x608
        release_trap();
        ins(32'h700, 0, 0, 0, 1);
        cyc(1, 32'h704, 32'h708, 1, 0, 32'hA00, 0, 0, 0, 0, 0);
        cyc(1, 32'h708, 32'hA00, 0, 1, '0, 0, 0, 0, 0, 0); // R7 over slot -> 0xA00
        release_trap();
        ins(32'hB00, 1, 1, 1, 1);                    // R8 same instruction
        release_trap();
        ins(32'hC00, 0, 0, 0, 1);
        ins(32'hC04, 1, 0, 0, 0);                    // R8 over pending -> 0xC04
        release_trap();
        ins(32'hD00, 0, 0, 0, 0);                    // R8 pending was dropped
        ins(32'hD04, 0, 0, 0, 0);

        // random stream
        rpc = 32'h1000; rtgt = '0; prev_br = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            v = ($urandom % 5) != 0;
            if (!v) begin
                cyc(0, '0, '0, 0, 0, '0, ($urandom % 4) == 0, 0, 0, 0,
                    m_trapped && ($urandom % 3) == 0);
            end else if (prev_br) begin
                prev_br = 1'b0;
                cyc(1, rpc, rtgt, 0, 1, '0, ($urandom % 12) == 0, ($urandom % 12) == 0,
                    ($urandom % 12) == 0, ($urandom % 12) == 0,
                    m_trapped && ($urandom % 3) == 0);
                rpc = rtgt;
            end else begin
                db  = ($urandom % 5) == 0;
                tgt = {$urandom} & 32'h0000_FFFC;
                cyc(1, rpc, rpc + 4, db, 0, tgt, ($urandom % 12) == 0,
                    ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0,
                    m_trapped && ($urandom % 3) == 0);
                if (db) begin
                    prev_br = 1'b1; rtgt = tgt;
                end
                rpc = rpc + 4;
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule